// File: doc/BRIEF.md
# Sequenced Multi-Domain Reset Controller

This block turns one raw, active-low reset into one reset per clock domain. A low level on the raw reset drives every domain reset low at once, with no clock needed. Each domain leaves reset on an edge of its own clock, through a flop chain local to that domain. Domain 0 is the lead domain. The other domains are followers.

There are two release policies. In sequenced mode the lead domain leaves reset first. Each follower then waits for `lead_ready_i`, which the lead domain raises once its logic is running. That signal is brought into each follower's clock through two flops. In independent mode every domain leaves reset on its own clock, close in time to the others, and the ready signal is ignored. Each domain takes its copy of the policy select only while that domain is held in reset.

The reset pins carry no data, so there is no valid/ready interface. `lead_ready_i` is a plain level, and the block never applies back-pressure.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `arst_ni` is low, every bit of `dom_rst_no` is low. The outputs fall as soon as `arst_ni` falls, with no clock edge in between.
- R2: After `arst_ni` rises, `dom_rst_no[0]` goes high on the second rising edge of `dom_clk_i[0]`.
- R3: With the policy set to independent (`indep_mode_i` = 1), each follower k goes high on the third rising edge of `dom_clk_i[k]` after `arst_ni` rises, whatever `lead_ready_i` does.
- R4: With the policy set to sequenced (`indep_mode_i` = 0), no follower output is high unless `dom_rst_no[0]` is already high.
- R5: In sequenced mode, follower k goes high on the first rising edge of `dom_clk_i[k]` at which both of these hold: the domain's own two-edge reset chain has completed, and `lead_ready_i` was sampled high on the two preceding edges of that clock. The earliest this can happen is the third edge after `arst_ni` rises. Until then the follower stays low.
- R6: A follower captures `indep_mode_i` only on clock edges where its own reset chain has not yet completed. A change to `indep_mode_i` after that point has no effect until `arst_ni` is next asserted.
- R7: Once a domain is out of reset, it stays out of reset until `arst_ni` falls, even if `lead_ready_i` later drops.
- R8: If `arst_ni` is asserted at any point, including in the middle of a release, all outputs return to reset. The whole sequence then restarts, so in sequenced mode the followers wait for `lead_ready_i` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_ni | input | 1 | Raw asynchronous reset, active low |
| dom_clk_i | input | NDOM | One clock per domain; bit 0 is the lead domain |
| lead_ready_i | input | 1 | Lead-domain logic is running (lead clock domain) |
| indep_mode_i | input | 1 | Release policy: 0 sequenced, 1 independent |
| dom_rst_no | output | NDOM | Per-domain reset, active low, released on its own clock |

## Verification
The bench uses the default parameters: three domains and two-flop synchronizers. It drives the three clocks at unrelated periods of 20, 28 and 34 ns, so the followers see the ready signal arrive at different phases of their own clocks. These settings cover every R5 release latency, a policy change after release, a reset asserted partway through a release, and a ready signal that drops after all domains are out of reset. A behavioural model counts edges in each domain and is compared against every domain output on every rising clock edge.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/100ps
package rstseq_pkg;
  typedef enum logic {
    REL_SEQUENCED   = 1'b0,
    REL_INDEPENDENT = 1'b1
  } rel_mode_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/100ps
// Reset synchronizer: clears at once, releases after STAGES edges.
module rstseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_bitsync.sv
`timescale 1ns/100ps
// Level synchronizer, cleared by the raw reset.
module rstseq_bitsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rstseq_follower.sv
`timescale 1ns/100ps
// Follower domain: own reset chain, synchronized lead-ready gate,
// policy captured while held, sticky release flop.
module rstseq_follower
  import rstseq_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic lead_ready_i,
  input  logic mode_i,
  output logic rst_no,
  output logic indep_o
);
  logic      base_rel;
  logic      rdy_sync;
  rel_mode_e mode_q;
  logic      rel_q;

  rstseq_sync #(.STAGES(STAGES)) u_base (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (base_rel)
  );

  rstseq_bitsync #(.STAGES(STAGES)) u_rdy (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .d_i    (lead_ready_i),
    .q_o    (rdy_sync)
  );

  // Policy is only taken while this domain is still held.
  always_ff @(posedge clk_i) begin
    if (!base_rel) mode_q <= rel_mode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rel_q <= 1'b0;
    else          rel_q <= rel_q | (base_rel & ((mode_q == REL_INDEPENDENT) | rdy_sync));
  end

  assign rst_no  = rel_q;
  assign indep_o = (mode_q == REL_INDEPENDENT);

  // R5: sequenced release only after the synchronized ready was seen
  p_wait_ready_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
    ($rose(rel_q) && mode_q == REL_SEQUENCED) |-> $past(rdy_sync));

  // R7: a released domain stays released
  p_sticky_release_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rel_q |=> rel_q);

  // R6: policy frozen once the reset chain has completed
  p_mode_frozen_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    base_rel |=> $stable(mode_q));
endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/100ps
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned NDOM        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            arst_ni,
  input  logic [NDOM-1:0] dom_clk_i,
  input  logic            lead_ready_i,
  input  logic            indep_mode_i,
  output logic [NDOM-1:0] dom_rst_no
);
  localparam int unsigned LAST_DOM = NDOM - 1;

  if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
    $error("SYNC_STAGES below minimum");
  end

  logic [LAST_DOM:1] indep_w;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_lead (
    .clk_i  (dom_clk_i[0]),
    .arst_ni(arst_ni),
    .rst_no (dom_rst_no[0])
  );

  for (genvar k = 1; k <= LAST_DOM; k++) begin : g_fol
    rstseq_follower #(.STAGES(SYNC_STAGES)) u_fol (
      .clk_i       (dom_clk_i[k]),
      .arst_ni     (arst_ni),
      .lead_ready_i(lead_ready_i),
      .mode_i      (indep_mode_i),
      .rst_no      (dom_rst_no[k]),
      .indep_o     (indep_w[k])
    );

    // R4: in sequenced mode a follower is never out before the lead
    p_lead_first_r4: assert property (@(posedge dom_clk_i[k]) disable iff (!arst_ni)
      (dom_rst_no[k] && !indep_w[k]) |-> dom_rst_no[0]);
  end
endmodule

// File: tb/rstseq_ctrl_test.sv
`timescale 1ns/100ps
module rstseq_ctrl_test;
  localparam int NDOM = 3;

  logic arst_n = 1'b0;
  logic clk0 = 1'b0, clk1 = 1'b0, clk2 = 1'b0;
  logic rdy0 = 1'b0;
  logic mode = 1'b0;
  wire  [NDOM-1:0] clkv = {clk2, clk1, clk0};
  wire  [NDOM-1:0] rst_n;
  wire  [NDOM-1:0] expv;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  rstseq_ctrl #(.NDOM(NDOM), .SYNC_STAGES(2)) uut (
    .arst_ni     (arst_n),
    .dom_clk_i   (clkv),
    .lead_ready_i(rdy0),
    .indep_mode_i(mode),
    .dom_rst_no  (rst_n)
  );

  initial forever #10 clk0 = ~clk0;
  initial begin #3; forever #14 clk1 = ~clk1; end
  initial begin #6; forever #17 clk2 = ~clk2; end

  task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp_v);
    end
  endtask

  // Behavioural model: edge counters per domain
  for (genvar k = 0; k < NDOM; k++) begin : g_mdl
    int bcnt = 0;
    int rcnt = 0;
    bit ind = 1'b0;
    bit ev = 1'b0;
    always @(posedge clkv[k] or negedge arst_n) begin
      bit base_done, rdy_ok, ind_old;
      if (!arst_n) begin
        bcnt = 0; rcnt = 0; ev = 1'b0; ind = mode;
      end else begin
        base_done = (bcnt >= 2);
        rdy_ok    = (rcnt >= 2);
        ind_old   = ind;
        if (!base_done) ind = mode;
        if (k == 0) ev = (bcnt >= 1);
        else        ev = ev | (base_done && (ind_old || rdy_ok));
        if (bcnt < 8) bcnt++;
        if (rdy0 && rcnt < 8) rcnt++;
      end
    end
    assign expv[k] = ev;
  end

  // Compare every domain on every rising clock edge
  always @(posedge clk0 or posedge clk1 or posedge clk2) begin
    #0.2;
    if (!done) begin
      chk(rst_n[0] == expv[0], "R2 lead release", rst_n, expv);
      chk(rst_n[2:1] == expv[2:1], g_mdl[1].ind ? "R3 follower release" : "R5 follower release",
          rst_n, expv);
    end
  end

  task automatic wait0(input int n);
    repeat (n) @(posedge clk0);
    #0.5;
  endtask

  initial begin
    // reset state
    mode = 1'b0; rdy0 = 1'b0; arst_n = 1'b0;
    wait0(5);
    chk(rst_n == 3'b000, "R1 reset state", rst_n, 3'b000);

    // R2: lead on second edge
    arst_n = 1'b1;
    wait0(1);
    chk(rst_n[0] == 1'b0, "R2 one edge", rst_n, 3'b000);
    wait0(1);
    chk(rst_n[0] == 1'b1, "R2 two edges", rst_n, 3'b001);

    // R4 R5: followers wait for ready
    wait0(20);
    chk(rst_n == 3'b001, "R4 R5 followers held", rst_n, 3'b001);

    // R6: late policy change ignored
    mode = 1'b1;
    wait0(20);
    chk(rst_n == 3'b001, "R6 late mode ignored", rst_n, 3'b001);

    rdy0 = 1'b1;
    wait0(10);
    chk(rst_n == 3'b111, "R5 release after ready", rst_n, 3'b111);

    // R7: ready drop does not re-reset
    rdy0 = 1'b0;
    wait0(10);
    chk(rst_n == 3'b111, "R7 sticky release", rst_n, 3'b111);

    // R1: asynchronous assertion between edges
    arst_n = 1'b0;
    #0.1;
    chk(rst_n == 3'b000, "R1 async assert", rst_n, 3'b000);

    // R3: independent release, ready never raised
    wait0(5);
    arst_n = 1'b1;
    wait0(10);
    chk(rst_n == 3'b111, "R3 independent", rst_n, 3'b111);

    // R8: reassert mid-release, then full restart in sequenced mode
    arst_n = 1'b0;
    mode = 1'b0;
    wait0(3);
    arst_n = 1'b1;
    wait0(1);
    arst_n = 1'b0;
    #0.1;
    chk(rst_n == 3'b000, "R8 mid-release reassert", rst_n, 3'b000);
    wait0(3);
    arst_n = 1'b1;
    wait0(20);
    chk(rst_n == 3'b001, "R8 restart waits for ready", rst_n, 3'b001);
    rdy0 = 1'b1;
    wait0(10);
    chk(rst_n == 3'b111, "R8 restart completes", rst_n, 3'b111);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule